// File: doc/BRIEF.md
# Instruction Operand Mode Decoder

This block takes one 16-bit instruction word and turns its two operand specifiers into concrete actions. The word carries a 5-bit opcode, a 5-bit destination specifier and a 6-bit source specifier. The block resolves the source to a value and the destination to a write target. To do so it may fetch extra instruction words through a next-word handshake and read memory through a request/acknowledge port. It also adjusts a working copy of the stack pointer for pushes and pops and advances a working copy of the program counter.

An instruction starts with a `start` pulse, which latches the word, PC, SP and a skip flag. The source operand is resolved first, then the destination operand. A `done` pulse then presents the source value, the updated PC and SP, the number of extra words consumed and a flag that marks the special-opcode group. Later, the execution logic supplies the result on `wb_valid`/`wb_data`. The block then raises exactly one write strobe for the latched target. In skip mode the operands are only stepped over: words are counted against PC, but nothing is fetched, read or written.

Top module: `opd_decoder`

## Requirements
- R1: The opcode is instr[4:0], the destination specifier is instr[9:5] and the source specifier is instr[15:10]. When the opcode is zero, `special` is 1 at `done`, only the source is resolved, SP is unaffected by the destination field, and `wb_valid` produces no write strobe.
- R2: Source codes 0x00–0x07 yield register `rf_flat[16*k +: 16]` with k = code. Codes 0x08–0x0F issue a memory read at that register's value and yield the returned data.
- R3: Codes 0x10–0x17 address memory at register k plus the next word, modulo 2^16. As a source this is read; as a destination it is the write address.
- R4: Code 0x18 as source reads [SP] and leaves SP+1. As destination it first decrements the SP left by the source and then targets that address. The decrement wraps from 0 to 0xFFFF.
- R5: Code 0x19 addresses [SP] with SP unchanged. Code 0x1A addresses [SP + next word].
- R6: Codes 0x1B, 0x1C and 0x1D yield SP, PC (the address after the instruction word, advanced by words already consumed) and EX as a source. As a destination they raise `sp_we`, `pc_we` and `ex_we` respectively.
- R7: Code 0x1E addresses [next word]. Code 0x1F as a source yields the next word itself.
- R8: Source codes 0x20–0x3F yield the literal (code − 0x21) as a 16-bit two's-complement value, covering −1 to 30.
- R9: Each operand using a next word (0x10–0x17, 0x1A, 0x1E, 0x1F) adds one to `pc_out` and one to `nw_used`.
- R10: Destination 0x1F consumes its next word and advances PC, but `wb_valid` raises no strobe.
- R11: With `skip_in` set, no `nw_req` or `rd_req` is raised and SP is unchanged. PC and `nw_used` still advance per next-word operand, and no write follows.
- R12: When both operands take a next word, the first word delivered belongs to the source and the second to the destination.
- R13: Destination codes 0x00–0x07 raise `rf_we` with `rf_widx` = code. Memory-addressing destinations raise only `mem_we` with `wr_addr` (no read). `wr_data` equals `wb_data`, and at most one strobe is high in any cycle.
- R14: After reset, `done`, all write strobes, `nw_req` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding `instr` (accepted while idle) |
| instr | input | 16 | Instruction word |
| skip_in | input | 1 | Step over operands without evaluating them |
| pc_in | input | DW | Address following the instruction word |
| sp_in | input | DW | Stack pointer at start |
| ex_in | input | DW | Overflow register value |
| rf_flat | input | NREG*DW | Register file contents, register k at bits [DW*k +: DW] |
| nw_req | output | 1 | Request for the next instruction word |
| nw_valid | input | 1 | Next word delivered |
| nw_data | input | DW | Next word value |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | DW | Memory read address |
| rd_ack | input | 1 | Read data returned |
| rd_data | input | DW | Read data |
| done | output | 1 | Operands resolved (one-cycle pulse) |
| special | output | 1 | Opcode field was zero |
| a_value | output | DW | Resolved source value |
| pc_out | output | DW | PC after consumed next words |
| sp_out | output | DW | SP after push/pop adjustment |
| nw_used | output | 2 | Next words consumed |
| wb_valid | input | 1 | Result ready for the destination |
| wb_data | input | DW | Result to write |
| rf_we | output | 1 | Register write strobe |
| rf_widx | output | 3 | Register write index |
| sp_we | output | 1 | SP write strobe |
| pc_we | output | 1 | PC write strobe |
| ex_we | output | 1 | EX write strobe |
| mem_we | output | 1 | Memory write strobe |
| wr_addr | output | DW | Memory write address |
| wr_data | output | DW | Write data for any strobe |

## Verification
The assertions assume that `nw_valid` and `rd_ack` rise only in answer to a pending request, and that `start` arrives only while the block is idle. They also assume that `rf_flat` and `ex_in` hold steady while an instruction is in flight. The bench meets these assumptions by answering each request one half-cycle after it appears and dropping the answer once the request falls. It also issues `start` only after the previous `done` and write phase, and keeps the register file constant. Within those limits it sweeps every source code, every destination code and both skip variants. Expected values come from an arithmetic model of the memory, the register file and the next-word stream.

// File: rtl/opd_pkg.sv
package opd_pkg;

  localparam int unsigned INSTR_W = 16;
  localparam int unsigned OPC_W   = 5;
  localparam int unsigned SRC_W   = 6;
  localparam int unsigned DST_W   = 5;

  typedef enum logic [3:0] {
    M_REG, M_REG_IND, M_REG_OFS, M_STACK, M_PEEK, M_PICK,
    M_SP, M_PC, M_EX, M_ABS, M_NWLIT, M_LIT
  } mode_e;

  typedef enum logic [2:0] {
    T_NONE, T_REG, T_MEM, T_SP, T_PC, T_EX
  } tgt_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_NW, S_RES, S_RD, S_DONE, S_WB
  } st_e;

  typedef struct packed {
    mode_e       mode;
    logic [2:0]  ridx;
    logic        uses_nw;
    logic [SRC_W-1:0] code;
  } opd_class_t;

endpackage

// File: rtl/opd_classify.sv
module opd_classify
  import opd_pkg::*;
(
  input  logic [SRC_W-1:0] code,
  output opd_class_t       cls
);
  always_comb begin
    cls.code    = code;
    cls.ridx    = code[2:0];
    cls.uses_nw = 1'b0;
    cls.mode    = M_LIT;
    if (!code[5]) begin
      case (code[4:3])
        2'b00: cls.mode = M_REG;
        2'b01: cls.mode = M_REG_IND;
        2'b10: begin cls.mode = M_REG_OFS; cls.uses_nw = 1'b1; end
        default: begin
          case (code[2:0])
            3'd0: cls.mode = M_STACK;
            3'd1: cls.mode = M_PEEK;
            3'd2: begin cls.mode = M_PICK; cls.uses_nw = 1'b1; end
            3'd3: cls.mode = M_SP;
            3'd4: cls.mode = M_PC;
            3'd5: cls.mode = M_EX;
            3'd6: begin cls.mode = M_ABS; cls.uses_nw = 1'b1; end
            default: begin cls.mode = M_NWLIT; cls.uses_nw = 1'b1; end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/opd_resolve.sv
module opd_resolve
  import opd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  opd_class_t         cls,
  input  logic               is_dst,
  input  logic [NREG*DW-1:0] rf_flat,
  input  logic [DW-1:0]      sp,
  input  logic [DW-1:0]      pc,
  input  logic [DW-1:0]      ex,
  input  logic [DW-1:0]      nw,
  output logic               is_mem,
  output logic [DW-1:0]      addr,
  output logic [DW-1:0]      imm,
  output logic [DW-1:0]      sp_nx,
  output tgt_e               tgt
);
  localparam logic [DW-1:0] LIT_BIAS = DW'(33);

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] rsel;
  logic [DW-1:0] lit;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign regs[g] = rf_flat[g*DW +: DW];
  end

  assign rsel = regs[cls.ridx];
  assign lit  = {{(DW-SRC_W){1'b0}}, cls.code} - LIT_BIAS;

  always_comb begin
    is_mem = 1'b0;
    addr   = sp;
    imm    = '0;
    sp_nx  = sp;
    tgt    = T_NONE;
    case (cls.mode)
      M_REG:     begin imm = rsel; tgt = T_REG; end
      M_REG_IND: begin is_mem = 1'b1; addr = rsel; tgt = T_MEM; end
      M_REG_OFS: begin is_mem = 1'b1; addr = rsel + nw; tgt = T_MEM; end
      M_STACK: begin
        is_mem = 1'b1;
        tgt    = T_MEM;
        if (is_dst) begin
          addr  = sp - DW'(1);
          sp_nx = sp - DW'(1);
        end else begin
          addr  = sp;
          sp_nx = sp + DW'(1);
        end
      end
      M_PEEK:  begin is_mem = 1'b1; addr = sp; tgt = T_MEM; end
      M_PICK:  begin is_mem = 1'b1; addr = sp + nw; tgt = T_MEM; end
      M_SP:    begin imm = sp; tgt = T_SP; end
      M_PC:    begin imm = pc; tgt = T_PC; end
      M_EX:    begin imm = ex; tgt = T_EX; end
      M_ABS:   begin is_mem = 1'b1; addr = nw; tgt = T_MEM; end
      M_NWLIT: begin imm = nw; tgt = T_NONE; end
      default: begin imm = lit; tgt = T_NONE; end
    endcase
  end
endmodule

// File: rtl/opd_decoder.sv
module opd_decoder
  import opd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [15:0]        instr,
  input  logic               skip_in,
  input  logic [DW-1:0]      pc_in,
  input  logic [DW-1:0]      sp_in,
  input  logic [DW-1:0]      ex_in,
  input  logic [NREG*DW-1:0] rf_flat,
  output logic               nw_req,
  input  logic               nw_valid,
  input  logic [DW-1:0]      nw_data,
  output logic               rd_req,
  output logic [DW-1:0]      rd_addr,
  input  logic               rd_ack,
  input  logic [DW-1:0]      rd_data,
  output logic               done,
  output logic               special,
  output logic [DW-1:0]      a_value,
  output logic [DW-1:0]      pc_out,
  output logic [DW-1:0]      sp_out,
  output logic [1:0]         nw_used,
  input  logic               wb_valid,
  input  logic [DW-1:0]      wb_data,
  output logic               rf_we,
  output logic [2:0]         rf_widx,
  output logic               sp_we,
  output logic               pc_we,
  output logic               ex_we,
  output logic               mem_we,
  output logic [DW-1:0]      wr_addr,
  output logic [DW-1:0]      wr_data
);
  st_e              state;
  logic             phase;
  logic [15:0]      inst_q;
  logic             skip_q;
  logic [DW-1:0]    pc_q, sp_q, nw_q;
  logic [1:0]       cnt_q;
  tgt_e             tgt_q;
  logic [DW-1:0]    tgt_addr_q;
  logic [2:0]       tgt_idx_q;

  logic [SRC_W-1:0] cur_code;
  logic             is_special;
  opd_class_t       cls;
  logic             r_is_mem;
  logic [DW-1:0]    r_addr, r_imm, r_sp_nx;
  tgt_e             r_tgt;

  assign is_special = (inst_q[OPC_W-1:0] == '0);
  assign cur_code   = phase ? {1'b0, inst_q[OPC_W+DST_W-1:OPC_W]}
                            : inst_q[INSTR_W-1:OPC_W+DST_W];

  opd_classify u_cls (
    .code (cur_code),
    .cls  (cls)
  );

  opd_resolve #(.DW(DW), .NREG(NREG)) u_res (
    .cls     (cls),
    .is_dst  (phase),
    .rf_flat (rf_flat),
    .sp      (sp_q),
    .pc      (pc_q),
    .ex      (ex_in),
    .nw      (nw_q),
    .is_mem  (r_is_mem),
    .addr    (r_addr),
    .imm     (r_imm),
    .sp_nx   (r_sp_nx),
    .tgt     (r_tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      phase      <= 1'b0;
      inst_q     <= '0;
      skip_q     <= 1'b0;
      pc_q       <= '0;
      sp_q       <= '0;
      nw_q       <= '0;
      cnt_q      <= '0;
      tgt_q      <= T_NONE;
      tgt_addr_q <= '0;
      tgt_idx_q  <= '0;
      nw_req     <= 1'b0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      done       <= 1'b0;
      special    <= 1'b0;
      a_value    <= '0;
      pc_out     <= '0;
      sp_out     <= '0;
      nw_used    <= '0;
      rf_we      <= 1'b0;
      rf_widx    <= '0;
      sp_we      <= 1'b0;
      pc_we      <= 1'b0;
      ex_we      <= 1'b0;
      mem_we     <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      done   <= 1'b0;
      rf_we  <= 1'b0;
      sp_we  <= 1'b0;
      pc_we  <= 1'b0;
      ex_we  <= 1'b0;
      mem_we <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            inst_q <= instr;
            pc_q   <= pc_in;
            sp_q   <= sp_in;
            skip_q <= skip_in;
            cnt_q  <= '0;
            phase  <= 1'b0;
            tgt_q  <= T_NONE;
            state  <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (cls.uses_nw) begin
            if (skip_q) begin
              pc_q  <= pc_q + DW'(1);
              cnt_q <= cnt_q + 2'd1;
              state <= S_RES;
            end else begin
              nw_req <= 1'b1;
              state  <= S_NW;
            end
          end else begin
            state <= S_RES;
          end
        end
        S_NW: begin
          if (nw_valid) begin
            nw_q   <= nw_data;
            nw_req <= 1'b0;
            pc_q   <= pc_q + DW'(1);
            cnt_q  <= cnt_q + 2'd1;
            state  <= S_RES;
          end
        end
        S_RES: begin
          if (!phase) begin
            if (!skip_q && r_is_mem) begin
              rd_req  <= 1'b1;
              rd_addr <= r_addr;
              sp_q    <= r_sp_nx;
              state   <= S_RD;
            end else begin
              if (!skip_q) begin
                a_value <= r_imm;
                sp_q    <= r_sp_nx;
              end
              if (is_special) state <= S_DONE;
              else begin
                phase <= 1'b1;
                state <= S_FETCH;
              end
            end
          end else begin
            if (!skip_q) begin
              tgt_q      <= r_tgt;
              tgt_addr_q <= r_addr;
              tgt_idx_q  <= cls.ridx;
              sp_q       <= r_sp_nx;
            end
            state <= S_DONE;
          end
        end
        S_RD: begin
          if (rd_ack) begin
            a_value <= rd_data;
            rd_req  <= 1'b0;
            if (is_special) state <= S_DONE;
            else begin
              phase <= 1'b1;
              state <= S_FETCH;
            end
          end
        end
        S_DONE: begin
          done    <= 1'b1;
          special <= is_special;
          pc_out  <= pc_q;
          sp_out  <= sp_q;
          nw_used <= cnt_q;
          state   <= (skip_q || is_special) ? S_IDLE : S_WB;
        end
        S_WB: begin
          if (wb_valid) begin
            wr_data <= wb_data;
            case (tgt_q)
              T_REG: begin rf_we <= 1'b1; rf_widx <= tgt_idx_q; end
              T_MEM: begin mem_we <= 1'b1; wr_addr <= tgt_addr_q; end
              T_SP:  sp_we <= 1'b1;
              T_PC:  pc_we <= 1'b1;
              T_EX:  ex_we <= 1'b1;
              default: ;
            endcase
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opd_decoder_chk.sv
module opd_decoder_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          idle,
  input logic          skip_q,
  input logic [DW-1:0] pc_in,
  input logic [DW-1:0] sp_in,
  input logic          nw_req,
  input logic          nw_valid,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [DW-1:0] rd_addr,
  input logic          done,
  input logic [DW-1:0] pc_out,
  input logic [DW-1:0] sp_out,
  input logic [1:0]    nw_used,
  input logic          wb_valid,
  input logic          rf_we,
  input logic          sp_we,
  input logic          pc_we,
  input logic          ex_we,
  input logic          mem_we
);
  logic [DW-1:0] pc_base, sp_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_base <= '0;
      sp_base <= '0;
    end else if (start && idle) begin
      pc_base <= pc_in;
      sp_base <= sp_in;
    end
  end

  // R11
  skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    skip_q |-> (!nw_req && !rd_req));

  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we, sp_we, pc_we, ex_we, mem_we}));

  // R13
  strobe_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we || sp_we || pc_we || ex_we || mem_we) |-> $past(wb_valid));

  // R12
  nw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (nw_req && !nw_valid) |=> nw_req);

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R9
  pc_span_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ((pc_out - pc_base) == {{(DW-2){1'b0}}, nw_used}));

  // R4
  sp_span_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (sp_out == sp_base || sp_out == sp_base + DW'(1) ||
              sp_out == sp_base - DW'(1)));

  // R14
  quiet_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!done && !nw_req && !rd_req && !mem_we && !rf_we));
endmodule

bind opd_decoder opd_decoder_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .idle     (state == opd_pkg::S_IDLE),
  .skip_q   (skip_q),
  .pc_in    (pc_in),
  .sp_in    (sp_in),
  .nw_req   (nw_req),
  .nw_valid (nw_valid),
  .rd_req   (rd_req),
  .rd_ack   (rd_ack),
  .rd_addr  (rd_addr),
  .done     (done),
  .pc_out   (pc_out),
  .sp_out   (sp_out),
  .nw_used  (nw_used),
  .wb_valid (wb_valid),
  .rf_we    (rf_we),
  .sp_we    (sp_we),
  .pc_we    (pc_we),
  .ex_we    (ex_we),
  .mem_we   (mem_we)
);

// File: tb/opd_decoder_bench.sv
module opd_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int NREG = 8;
  localparam logic [15:0] PC0 = 16'h0200;
  localparam logic [15:0] EX0 = 16'hBEEF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] instr = '0;
  logic skip_in = 1'b0;
  logic [DW-1:0] pc_in = PC0, sp_in = 16'hFFF0, ex_in = EX0;
  logic [NREG*DW-1:0] rf_flat;
  logic nw_req, nw_valid = 1'b0;
  logic [DW-1:0] nw_data = '0;
  logic rd_req, rd_ack = 1'b0;
  logic [DW-1:0] rd_addr, rd_data = '0;
  logic done, special;
  logic [DW-1:0] a_value, pc_out, sp_out;
  logic [1:0] nw_used;
  logic wb_valid = 1'b0;
  logic [DW-1:0] wb_data = '0;
  logic rf_we, sp_we, pc_we, ex_we, mem_we;
  logic [2:0] rf_widx;
  logic [DW-1:0] wr_addr, wr_data;

  int n_checks = 0;
  int n_fails  = 0;
  int nw_cnt   = 0;
  int rd_cnt   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] rv(int i);
    return 16'h0100 * 16'(i + 1) + 16'(i);
  endfunction
  function automatic logic [15:0] memf(logic [15:0] a);
    return a ^ 16'h5A5A;
  endfunction
  function automatic logic [15:0] nwf(int n);
    return 16'h0040 + 16'(n) * 16'h0003;
  endfunction
  function automatic bit uses(int c);
    return (c >= 16 && c < 24) || c == 26 || c == 30 || c == 31;
  endfunction

  for (genvar g = 0; g < NREG; g++) begin : g_rf
    assign rf_flat[g*DW +: DW] = rv(g);
  end

  opd_decoder #(.DW(DW), .NREG(NREG)) u_opd_decoder (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .skip_in(skip_in),
    .pc_in(pc_in), .sp_in(sp_in), .ex_in(ex_in), .rf_flat(rf_flat),
    .nw_req(nw_req), .nw_valid(nw_valid), .nw_data(nw_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .done(done), .special(special), .a_value(a_value), .pc_out(pc_out),
    .sp_out(sp_out), .nw_used(nw_used), .wb_valid(wb_valid), .wb_data(wb_data),
    .rf_we(rf_we), .rf_widx(rf_widx), .sp_we(sp_we), .pc_we(pc_we),
    .ex_we(ex_we), .mem_we(mem_we), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Responders answer half a cycle after a request appears.
  always @(negedge clk) begin
    if (rd_req && !rd_ack) begin
      rd_ack  <= 1'b1;
      rd_data <= memf(rd_addr);
      rd_cnt  <= rd_cnt + 1;
    end else rd_ack <= 1'b0;
    if (nw_req && !nw_valid) begin
      nw_valid <= 1'b1;
      nw_data  <= nwf(nw_cnt);
      nw_cnt   <= nw_cnt + 1;
    end else nw_valid <= 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] w, input bit skp, input logic [15:0] sp0);
    instr = w; skip_in = skp; sp_in = sp0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(done, "R1 done pulse", {31'd0, done}, 32'd1);
  endtask

  task automatic wb(input logic [15:0] d, output logic [4:0] st);
    @(negedge clk); wb_valid = 1'b1; wb_data = d;
    @(negedge clk); wb_valid = 1'b0;
    st = {rf_we, sp_we, pc_we, ex_we, mem_we};
  endtask

  function automatic logic [15:0] mk(int a, int b, int op);
    return {6'(a), 5'(b), 5'(op)};
  endfunction

  initial begin
    logic [4:0] st;
    logic [15:0] sp0, nwa, exp_v, exp_a;
    logic [4:0] exp_st;
    int n0, r0;
    sp0 = 16'hFFF0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R14
    chk(!done && !nw_req && !rd_req, "R14 reset outputs",
        {29'd0, done, nw_req, rd_req}, 32'd0);
    chk({rf_we, sp_we, pc_we, ex_we, mem_we} == 5'd0, "R14 reset strobes",
        {27'd0, rf_we, sp_we, pc_we, ex_we, mem_we}, 32'd0);

    // Source sweep: all 64 codes, destination register A.
    for (int c = 0; c < 64; c++) begin
      n0 = nw_cnt; nwa = nwf(n0);
      run(mk(c, 0, 1), 1'b0, sp0);
      if (c < 8) exp_v = rv(c);                          // R2
      else if (c < 16) exp_v = memf(rv(c - 8));          // R2
      else if (c < 24) exp_v = memf(rv(c - 16) + nwa);   // R3
      else if (c == 24 || c == 25) exp_v = memf(sp0);    // R4 R5
      else if (c == 26) exp_v = memf(sp0 + nwa);         // R5
      else if (c == 27) exp_v = sp0;                     // R6
      else if (c == 28) exp_v = PC0;                     // R6
      else if (c == 29) exp_v = EX0;                     // R6
      else if (c == 30) exp_v = memf(nwa);               // R7
      else if (c == 31) exp_v = nwa;                     // R7
      else exp_v = 16'(c) - 16'd33;                      // R8
      chk(a_value == exp_v, "R2 R3 R5 R6 R7 R8 source value", {16'd0, a_value}, {16'd0, exp_v});
      chk(pc_out == PC0 + 16'(uses(c)) && nw_used == 2'(uses(c)), "R9 pc advance",
          {16'd0, pc_out}, {16'd0, PC0 + 16'(uses(c))});
      chk(sp_out == ((c == 24) ? sp0 + 16'd1 : sp0), "R4 source sp",
          {16'd0, sp_out}, {16'd0, (c == 24) ? sp0 + 16'd1 : sp0});
      wb(16'hC000 + 16'(c), st);
      chk(st == 5'b10000 && rf_widx == 3'd0 && wr_data == 16'hC000 + 16'(c),
          "R13 register write", {27'd0, st}, 32'h10);
    end

    // Destination sweep: all 32 codes, source literal 1.
    for (int c = 0; c < 32; c++) begin
      n0 = nw_cnt; nwa = nwf(n0);
      run(mk(16'h22, c, 2), 1'b0, sp0);
      chk(a_value == 16'd1, "R8 literal one", {16'd0, a_value}, 32'd1);
      exp_a = '0;
      if (c < 8) exp_st = 5'b10000;
      else if (c < 16) begin exp_st = 5'b00001; exp_a = rv(c - 8); end
      else if (c < 24) begin exp_st = 5'b00001; exp_a = rv(c - 16) + nwa; end
      else if (c == 24) begin exp_st = 5'b00001; exp_a = sp0 - 16'd1; end
      else if (c == 25) begin exp_st = 5'b00001; exp_a = sp0; end
      else if (c == 26) begin exp_st = 5'b00001; exp_a = sp0 + nwa; end
      else if (c == 27) exp_st = 5'b01000;
      else if (c == 28) exp_st = 5'b00100;
      else if (c == 29) exp_st = 5'b00010;
      else if (c == 30) begin exp_st = 5'b00001; exp_a = nwa; end
      else exp_st = 5'b00000;                            // R10
      chk(pc_out == PC0 + 16'(uses(c)), "R9 R10 dest pc", {16'd0, pc_out},
          {16'd0, PC0 + 16'(uses(c))});
      chk(sp_out == ((c == 24) ? sp0 - 16'd1 : sp0), "R4 dest sp",
          {16'd0, sp_out}, {16'd0, (c == 24) ? sp0 - 16'd1 : sp0});
      wb(16'hD000 + 16'(c), st);
      chk(st == exp_st, "R3 R6 R10 R13 dest strobe", {27'd0, st}, {27'd0, exp_st});
      if (exp_st == 5'b00001)
        chk(wr_addr == exp_a && wr_data == 16'hD000 + 16'(c), "R3 R5 R7 R13 dest address",
            {16'd0, wr_addr}, {16'd0, exp_a});
      if (c < 8)
        chk(rf_widx == 3'(c), "R13 dest index", {29'd0, rf_widx}, c);
    end

    // R4 pop then push: push lands where pop read.
    run(mk(24, 24, 1), 1'b0, sp0);
    wb(16'h1234, st);
    chk(a_value == memf(sp0) && sp_out == sp0 && wr_addr == sp0 && st == 5'b00001,
        "R4 pop then push", {16'd0, wr_addr}, {16'd0, sp0});

    // R4 push wraps below zero.
    run(mk(16'h21, 24, 1), 1'b0, 16'h0000);
    wb(16'h4321, st);
    chk(sp_out == 16'hFFFF && wr_addr == 16'hFFFF, "R4 push wrap",
        {16'd0, wr_addr}, 32'hFFFF);

    // R12 two next words: source takes the first.
    n0 = nw_cnt;
    run(mk(31, 30, 1), 1'b0, sp0);
    wb(16'h5555, st);
    chk(a_value == nwf(n0), "R12 source word first", {16'd0, a_value}, {16'd0, nwf(n0)});
    chk(wr_addr == nwf(n0 + 1), "R12 dest word second", {16'd0, wr_addr}, {16'd0, nwf(n0 + 1)});
    chk(pc_out == PC0 + 16'd2 && nw_used == 2'd2, "R9 two words", {16'd0, pc_out},
        {16'd0, PC0 + 16'd2});

    // R1 special group: destination field is not an operand.
    n0 = nw_cnt;
    run(mk(16, 24, 0), 1'b0, sp0);
    chk(special == 1'b1, "R1 special flag", {31'd0, special}, 32'd1);
    chk(a_value == memf(rv(0) + nwf(n0)) && sp_out == sp0 && pc_out == PC0 + 16'd1,
        "R1 special operand", {16'd0, sp_out}, {16'd0, sp0});
    wb(16'h7777, st);
    chk(st == 5'd0, "R1 special no write", {27'd0, st}, 32'd0);
    run(mk(0, 0, 1), 1'b0, sp0);
    chk(special == 1'b0, "R1 normal flag", {31'd0, special}, 32'd0);
    wb(16'h0001, st);

    // Skip sweeps: source codes with a word-using destination, then destinations.
    for (int c = 0; c < 64; c++) begin
      n0 = nw_cnt; r0 = rd_cnt;
      run(mk(c, 26, 1), 1'b1, sp0);
      chk(pc_out == PC0 + 16'(uses(c)) + 16'd1 && nw_used == 2'(uses(c) + 1),
          "R11 skip source pc", {16'd0, pc_out}, {16'd0, PC0 + 16'(uses(c)) + 16'd1});
      chk(sp_out == sp0 && nw_cnt == n0 && rd_cnt == r0, "R11 skip no access",
          {16'd0, sp_out}, {16'd0, sp0});
      wb(16'h9999, st);
      chk(st == 5'd0, "R11 skip no write", {27'd0, st}, 32'd0);
    end
    for (int c = 0; c < 32; c++) begin
      n0 = nw_cnt; r0 = rd_cnt;
      run(mk(8, c, 3), 1'b1, sp0);
      chk(pc_out == PC0 + 16'(uses(c)) && sp_out == sp0 && nw_cnt == n0 && rd_cnt == r0,
          "R11 skip dest", {16'd0, pc_out}, {16'd0, PC0 + 16'(uses(c))});
    end

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL R14 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule